// File: doc/BRIEF.md
# Local Bus Peripheral Register Slave

This block sits on a simple asynchronous-strobe memory-style local bus as a slave. It holds four word-wide registers: interrupt enable and sticky flag, per-pin GPIO direction, GPIO data, and a shared LED-write / DIP-switch-read word. Any access whose word address lies beyond those four is forwarded to an external connector. The connector carries the address, the read and write strobes, a region-qualified chip select, and a 32-bit data path with its own output-enable.

Two active-low interrupt inputs are brought into the clock domain through synchronizer chains. A falling edge on either one sets a sticky flag. Software reads the flag, enables the interrupt line, and clears the flag with any write to the interrupt word, whether or not interrupts are enabled. A register write is committed when the write strobe rises while chip select is still low. Reads are combinational from the address while chip select and the read strobe are both low.

Top module: `lbus_periph_slave`

## Requirements
- R1: After reset the interrupt enable and flag are 0, `irq` is 0, every GPIO pin is an input (`gpio_oe` all 0), `gpio_out` is 0 and all `led_n` bits are 1.
- R2: A read of word 0 (byte 0x0000) returns the enable in bit 1 and the flag in bit 0, with all other bits zero.
- R3: A write to word 0 loads the enable from data bit 1 and clears the flag, including when the enable is 0 before and after the write.
- R4: A falling edge on `btn_irq_n` or `usr_irq_n` sets the flag three clock edges after the edge. An input held low does not set the flag again after it has been cleared.
- R5: If an interrupt edge is detected on the same clock edge as a flag-clearing write commits, the flag ends up set.
- R6: `irq` is high exactly when both the flag and the enable are 1.
- R7: Word 1 (byte 0x0004) holds the GPIO direction in bits 15:0, where 1 means output and 0 means input. `gpio_oe` follows it bit by bit, and bits 31:16 read as zero.
- R8: Word 2 (byte 0x0008) stores the low 16 written bits, which appear on `gpio_out`. A read returns the `gpio_in` level for input bits and the stored value for output bits.
- R9: A write to word 3 (byte 0x000C) sets `led_n[i]` to the inverse of data bit i for i in 0..3. A read of word 3 returns `dip_in` in bits 7:0 and zero above.
- R10: A write commits only when `bus_wr_n` rises while `bus_cs_n` was low on the previous clock. A strobe that rises after chip select has gone high changes nothing.
- R11: `ext_addr`, `ext_rd_n` and `ext_wr_n` follow the bus inputs directly. `ext_cs_n` is low only when `bus_cs_n` is low and the word address is 4 or more.
- R12: While the external region is selected and `bus_wr_n` is low, `ext_data_oe` is 1 and `ext_data_o` equals `bus_wdata`. An external read returns `ext_data_i` on `bus_rdata`, and external writes leave the internal registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 13 | Word address (byte address bits 14:2) |
| bus_wdata | input | 32 | Write data from the bus master |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rdata | output | 32 | Read data to the bus master |
| irq | output | 1 | Interrupt request, active high |
| btn_irq_n | input | 1 | Push-button interrupt source, active low |
| usr_irq_n | input | 1 | External user interrupt source, active low |
| gpio_in | input | 16 | GPIO pin levels |
| gpio_out | output | 16 | GPIO drive values |
| gpio_oe | output | 16 | GPIO output enables |
| dip_in | input | 8 | DIP switch levels |
| led_n | output | 4 | LED drives, active low |
| ext_addr | output | 13 | External address, passthrough |
| ext_cs_n | output | 1 | External chip select, region-qualified |
| ext_rd_n | output | 1 | External read strobe, passthrough |
| ext_wr_n | output | 1 | External write strobe, passthrough |
| ext_data_o | output | 32 | External data driven during writes |
| ext_data_oe | output | 1 | External data output enable |
| ext_data_i | input | 32 | External data sampled during reads |

## Verification
The register path is exercised with write-then-read vectors on every internal word. The GPIO data vectors use a direction mask that mixes inputs and outputs, so the bench can tell pin levels apart from stored values bit by bit. The interrupt path is tried with each source separately, with the enable both on and off, and with a source held low after a clear. One case places an edge on exactly the same clock as a clearing write. Bus-protocol cases drop chip select before the write strobe rises, and access word addresses 4 and 5, which would alias onto internal words if the decode were wrong.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
   localparam int unsigned LBS_NUM_WORDS = 4;
   localparam int unsigned LBS_IDX_W     = 2;

   typedef enum logic [LBS_IDX_W-1:0] {
      W_IRQ   = 2'd0,
      W_GDIR  = 2'd1,
      W_GDAT  = 2'd2,
      W_LEDSW = 2'd3
   } lbs_word_e;
endpackage

// File: rtl/lbs_bus_front.sv
module lbs_bus_front
   import lbs_pkg::*;
#(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic                     cs_n,
   input  logic                     wr_n,
   output logic                     int_hit,
   output logic                     ext_hit,
   output logic [LBS_NUM_WORDS-1:0] wr_sel,
   output logic [DATA_W-1:0]        wr_data
);
   localparam int unsigned HI_W = ADDR_W - LBS_IDX_W;

   logic              cs_n_q, wr_n_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              commit;
   logic              int_q;

   if (ADDR_W <= LBS_IDX_W) begin : g_bad_addr
      $error("ADDR_W must exceed the internal index width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n_q <= 1'b1;
         wr_n_q <= 1'b1;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         cs_n_q <= cs_n;
         wr_n_q <= wr_n;
         addr_q <= addr;
         data_q <= wdata;
      end
   end

   assign int_hit = ~|addr[ADDR_W-1:LBS_IDX_W];
   assign ext_hit = ~int_hit;
   assign int_q   = (addr_q[ADDR_W-1:LBS_IDX_W] == HI_W'(0));
   assign commit  = ~cs_n_q & ~wr_n_q & wr_n;
   assign wr_data = data_q;

   for (genvar w = 0; w < LBS_NUM_WORDS; w++) begin : g_sel
      assign wr_sel[w] = commit & int_q & (addr_q[LBS_IDX_W-1:0] == LBS_IDX_W'(w));
   end

   p_sel_onehot_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel));
   p_commit_on_rise_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_sel) |-> ($rose(wr_n) && $past(!cs_n)));
endmodule

// File: rtl/lbs_irq_unit.sv
module lbs_irq_unit #(
   parameter int unsigned N_SRC       = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_n,
   input  logic             wr_en,
   input  logic             en_val,
   output logic             en,
   output logic             flag,
   output logic             irq
);
   logic [N_SRC-1:0] fall;
   logic             any_fall;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      logic [SYNC_STAGES-1:0] chain;
      logic                   last_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain  <= '1;
            last_q <= 1'b1;
         end else begin
            chain  <= {chain[SYNC_STAGES-2:0], src_n[s]};
            last_q <= chain[SYNC_STAGES-1];
         end
      end
      assign fall[s] = last_q & ~chain[SYNC_STAGES-1];
   end

   assign any_fall = |fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= 1'b0;
         flag <= 1'b0;
      end else begin
         if (wr_en) en <= en_val;
         if (any_fall)   flag <= 1'b1;
         else if (wr_en) flag <= 1'b0;
      end
   end

   assign irq = flag & en;

   p_edge_sets_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      any_fall |=> flag);
   p_edge_beats_clear_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (any_fall && wr_en) |=> flag);
   p_clear_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !any_fall) |=> !flag);
endmodule

// File: rtl/lbs_gpio_bank.sv
module lbs_gpio_bank #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         dir_wr,
   input  logic         dat_wr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pins_in,
   output logic [W-1:0] dir,
   output logic [W-1:0] pins_out,
   output logic [W-1:0] rd_dat
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dir[b]      <= 1'b0;
            pins_out[b] <= 1'b0;
         end else begin
            if (dir_wr) dir[b]      <= wdata[b];
            if (dat_wr) pins_out[b] <= wdata[b];
         end
      end
      assign rd_dat[b] = dir[b] ? pins_out[b] : pins_in[b];
   end

   p_dir_load_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      dir_wr |=> (dir == $past(wdata)));
   p_out_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !dat_wr |=> $stable(pins_out));
endmodule

// File: rtl/lbus_periph_slave.sv
module lbus_periph_slave
   import lbs_pkg::*;
#(
   parameter int unsigned ADDR_W      = 13,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned GPIO_W      = 16,
   parameter int unsigned DIP_W       = 8,
   parameter int unsigned LED_W       = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_cs_n,
   input  logic              bus_rd_n,
   input  logic              bus_wr_n,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   input  logic              btn_irq_n,
   input  logic              usr_irq_n,
   input  logic [GPIO_W-1:0] gpio_in,
   output logic [GPIO_W-1:0] gpio_out,
   output logic [GPIO_W-1:0] gpio_oe,
   input  logic [DIP_W-1:0]  dip_in,
   output logic [LED_W-1:0]  led_n,
   output logic [ADDR_W-1:0] ext_addr,
   output logic              ext_cs_n,
   output logic              ext_rd_n,
   output logic              ext_wr_n,
   output logic [DATA_W-1:0] ext_data_o,
   output logic              ext_data_oe,
   input  logic [DATA_W-1:0] ext_data_i
);
   if (GPIO_W > DATA_W || DIP_W > DATA_W || LED_W > DATA_W || DATA_W < 2) begin : g_bad_w
      $error("field widths must fit in the data word");
   end

   logic                     int_hit, ext_hit;
   logic [LBS_NUM_WORDS-1:0] wr_sel;
   logic [DATA_W-1:0]        wr_data;
   logic                     en, flag;
   logic [GPIO_W-1:0]        gpio_rd;
   logic [LED_W-1:0]         led_on;
   lbs_word_e                rd_word;

   lbs_bus_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_front (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .cs_n    (bus_cs_n),
      .wr_n    (bus_wr_n),
      .int_hit (int_hit),
      .ext_hit (ext_hit),
      .wr_sel  (wr_sel),
      .wr_data (wr_data)
   );

   lbs_irq_unit #(.N_SRC(2), .SYNC_STAGES(SYNC_STAGES)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_n  ({usr_irq_n, btn_irq_n}),
      .wr_en  (wr_sel[W_IRQ]),
      .en_val (wr_data[1]),
      .en     (en),
      .flag   (flag),
      .irq    (irq)
   );

   lbs_gpio_bank #(.W(GPIO_W)) u_gpio (
      .clk      (clk),
      .rst_n    (rst_n),
      .dir_wr   (wr_sel[W_GDIR]),
      .dat_wr   (wr_sel[W_GDAT]),
      .wdata    (wr_data[GPIO_W-1:0]),
      .pins_in  (gpio_in),
      .dir      (gpio_oe),
      .pins_out (gpio_out),
      .rd_dat   (gpio_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               led_on <= '0;
      else if (wr_sel[W_LEDSW]) led_on <= wr_data[LED_W-1:0];
   end
   assign led_n = ~led_on;

   assign rd_word = lbs_word_e'(bus_addr[LBS_IDX_W-1:0]);

   always_comb begin
      bus_rdata = '0;
      if (!bus_cs_n && !bus_rd_n) begin
         if (ext_hit) begin
            bus_rdata = ext_data_i;
         end else begin
            unique case (rd_word)
               W_IRQ:   begin bus_rdata[1] = en; bus_rdata[0] = flag; end
               W_GDIR:  bus_rdata[GPIO_W-1:0] = gpio_oe;
               W_GDAT:  bus_rdata[GPIO_W-1:0] = gpio_rd;
               W_LEDSW: bus_rdata[DIP_W-1:0]  = dip_in;
               default: bus_rdata = '0;
            endcase
         end
      end
   end

   assign ext_addr    = bus_addr;
   assign ext_rd_n    = bus_rd_n;
   assign ext_wr_n    = bus_wr_n;
   assign ext_cs_n    = bus_cs_n | int_hit;
   assign ext_data_oe = ~ext_cs_n & ~bus_wr_n;
   assign ext_data_o  = bus_wdata;

   p_ext_cs_qual_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      !ext_cs_n |-> (!bus_cs_n && (bus_addr >= ADDR_W'(LBS_NUM_WORDS))));
   p_ext_oe_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      ext_data_oe |-> (!bus_wr_n && !bus_cs_n && ext_hit));
   p_led_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_sel[W_LEDSW] |=> $stable(led_n));
   p_irq_gate_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!irq || $past(wr_sel[W_IRQ])));
endmodule

// File: tb/lbus_periph_slave_bench.sv
module lbus_periph_slave_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
   logic [31:0] bus_rdata;
   logic        irq;
   logic        btn_irq_n = 1'b1, usr_irq_n = 1'b1;
   logic [15:0] gpio_in = 16'hA5C3;
   logic [15:0] gpio_out, gpio_oe;
   logic [7:0]  dip_in = 8'h5A;
   logic [3:0]  led_n;
   logic [12:0] ext_addr;
   logic        ext_cs_n, ext_rd_n, ext_wr_n, ext_data_oe;
   logic [31:0] ext_data_o;
   logic [31:0] ext_data_i = 32'hDEADBEEF;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   logic [31:0] rd;

   always #10 clk = ~clk;

   lbus_periph_slave u_lbus_periph_slave (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
      .bus_rdata(bus_rdata), .irq(irq), .btn_irq_n(btn_irq_n), .usr_irq_n(usr_irq_n),
      .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .dip_in(dip_in),
      .led_n(led_n), .ext_addr(ext_addr), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
      .ext_wr_n(ext_wr_n), .ext_data_o(ext_data_o), .ext_data_oe(ext_data_oe),
      .ext_data_i(ext_data_i)
   );

   // word address, write data, expected read-back
   localparam logic [76:0] VEC [7] = '{
      {13'd1, 32'hFFFF00F0, 32'h000000F0},   // R7 direction, upper bits dropped
      {13'd2, 32'h12345678, 32'h0000A573},   // R8 mixed in/out read
      {13'd3, 32'hFFFFFFF5, 32'h0000005A},   // R9 DIP read
      {13'd0, 32'h00000002, 32'h00000002},   // R3 enable
      {13'd0, 32'hFFFFFFFD, 32'h00000000},   // R2 R3 disable, bits masked
      {13'd1, 32'h0000FFFF, 32'h0000FFFF},   // R7 all outputs
      {13'd2, 32'h00009ABC, 32'h00009ABC}    // R8 stored value read back
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [12:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
      @(negedge clk);
      bus_wr_n = 1'b1;
      @(negedge clk);
      bus_cs_n = 1'b1;
   endtask

   task automatic bus_read(logic [12:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_cs_n = 1'b0; bus_rd_n = 1'b0;
      #5 d = bus_rdata;
      bus_cs_n = 1'b1; bus_rd_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 irq", {31'd0, irq}, 32'd0);
      check("R1 gpio_oe", {16'd0, gpio_oe}, 32'd0);
      check("R1 gpio_out", {16'd0, gpio_out}, 32'd0);
      check("R1 led_n", {28'd0, led_n}, 32'hF);
      bus_read(13'd0, rd);
      check("R1 R2 irq word", rd, 32'd0);

      foreach (VEC[i]) begin
         bus_write(VEC[i][76:64], VEC[i][63:32]);
         bus_read(VEC[i][76:64], rd);
         check("vector", rd, VEC[i][31:0]);
      end
      check("R7 gpio_oe", {16'd0, gpio_oe}, 32'h0000FFFF);
      check("R8 gpio_out", {16'd0, gpio_out}, 32'h00009ABC);
      check("R9 led_n", {28'd0, led_n}, 32'hA);

      // R10: strobe rises after chip select released
      @(negedge clk);
      bus_addr = 13'd3; bus_wdata = 32'h0; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
      @(negedge clk); bus_cs_n = 1'b1;
      @(negedge clk); bus_wr_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R10 no commit", {28'd0, led_n}, 32'hA);

      // R11 R12 external region
      @(negedge clk);
      bus_addr = 13'd5; bus_wdata = 32'h0BADF00D; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
      #1;
      check("R11 ext_cs_n", {31'd0, ext_cs_n}, 32'd0);
      check("R11 ext_addr", {19'd0, ext_addr}, 32'd5);
      check("R11 ext_wr_n", {31'd0, ext_wr_n}, 32'd0);
      check("R12 ext_oe", {31'd0, ext_data_oe}, 32'd1);
      check("R12 ext_data_o", ext_data_o, 32'h0BADF00D);
      @(negedge clk); bus_wr_n = 1'b1;
      @(negedge clk); bus_cs_n = 1'b1;
      bus_write(13'd4, 32'h0);
      bus_write(13'd7, 32'h0);
      bus_read(13'd1, rd);
      check("R12 no alias dir", rd, 32'h0000FFFF);
      check("R12 no alias led", {28'd0, led_n}, 32'hA);
      @(negedge clk);
      bus_addr = 13'd2; bus_cs_n = 1'b0; #1;
      check("R11 internal not ext", {31'd0, ext_cs_n}, 32'd1);
      bus_cs_n = 1'b1;
      bus_read(13'd6, rd);
      check("R12 ext read", rd, 32'hDEADBEEF);

      // R4 R6 push-button edge with enable on
      bus_write(13'd0, 32'h2);
      check("R6 enabled no flag", {31'd0, irq}, 32'd0);
      @(negedge clk); btn_irq_n = 1'b0;
      repeat (4) @(negedge clk);
      bus_read(13'd0, rd);
      check("R4 button sets flag", rd, 32'h3);
      check("R6 irq high", {31'd0, irq}, 32'd1);
      btn_irq_n = 1'b1;
      bus_write(13'd0, 32'h0);
      bus_read(13'd0, rd);
      check("R3 disable and clear", rd, 32'h0);

      // R4 R6 user source with enable off, then clear while disabled
      @(negedge clk); usr_irq_n = 1'b0;
      repeat (4) @(negedge clk);
      bus_read(13'd0, rd);
      check("R4 user sets flag", rd, 32'h1);
      check("R6 irq gated off", {31'd0, irq}, 32'd0);
      bus_write(13'd0, 32'h0);
      repeat (6) @(negedge clk);
      bus_read(13'd0, rd);
      check("R3 R4 cleared while disabled, level ignored", rd, 32'h0);
      usr_irq_n = 1'b1;
      repeat (4) @(negedge clk);

      // R5 edge detected on the same edge as a clearing write
      @(negedge clk);
      bus_addr = 13'd0; bus_wdata = 32'h2; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
      btn_irq_n = 1'b0;
      @(negedge clk);
      @(negedge clk); bus_wr_n = 1'b1;
      @(negedge clk); bus_cs_n = 1'b1;
      bus_read(13'd0, rd);
      check("R5 edge beats clear", rd, 32'h3);
      check("R5 R6 irq", {31'd0, irq}, 32'd1);
      btn_irq_n = 1'b1;

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule